// File: doc/BRIEF.md
# I2C Register Target with Auto-Incrementing Pointer

This block is an I2C target that holds a bank of ten 8-bit control registers. The registers sit at addresses 0x00 through 0x09, and their contents are also driven out on a parallel port for use elsewhere in the chip. A controller on the bus can write a burst of bytes, read from wherever the pointer currently stands, or set the pointer and then read back from that location.

A single register pointer serves both directions. After every data byte, whether written or read, the pointer moves one register forward, and after register 0x09 it returns to 0x00. Because the pointer keeps its value between transfers, a read that sends no register address continues right after the last register that was touched.

The bus lines are sampled with the system clock. The block detects START and STOP conditions itself, and it pulls SDA low through an open-drain enable output.

Top module: `i2c_regbank_target`

## Requirements
- R1: After a synchronous reset, all ten registers read 0x00, the pointer is 0, and `sda_oe` is 0, which releases SDA.
- R2: The target acknowledges the address byte `{DEV_ADDR, 0}` and every byte after it. In a write, the first byte after the address loads the pointer. Each later byte is stored in the register at the pointer and appears on `regs_o` bits `[8*k+7:8*k]` for register k.
- R3: After each data byte, written or read, the pointer advances by one. From 0x09 it advances to 0x00.
- R4: A read that starts right after START with `{DEV_ADDR, 1}` returns the register at the pointer. That register is the one after the last register accessed, whether the last access was a read or a write.
- R5: A random read works as follows. START, the write address and one pointer byte are sent. Then a repeated START and the read address are sent. The read returns data from the register that the pointer byte selected.
- R6: Read data is shifted out MSB first. When the controller acknowledges a byte, the target sends the register at the advanced pointer next.
- R7: When the controller does not acknowledge a read byte and then sends STOP, the target no longer drives SDA.
- R8: If the address does not match `DEV_ADDR`, the target sends no acknowledge and never drives SDA. Bytes that follow, up to the next START or STOP, change neither the registers nor the pointer.
- R9: `sda_oe` changes only while SCL is low. It is 0 during the acknowledge bit that the controller sends after a read byte.
- R10: A pointer byte of `NREG` or more loads the pointer with 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the bus lines are sampled with it |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | SDA as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | NREG*8 | All registers; register k is at bits [8*k+7:8*k] |

## Verification
The bench writes a burst that runs across register 0x09. A pointer that sticks or that overruns into a register that does not exist would show up as wrong values on `regs_o` and as wrong read-back data. Current-address reads are issued both after a write and after a read, which catches a pointer that advances in only one direction. A random read whose burst wraps catches a target that ignores the dummy write or that skips the increment on the last byte. A foreign address followed by data bytes checks that such a target stays silent and leaves the registers and the pointer alone. An oversized pointer byte checks that the pointer is clamped to 0. During every read bit and every acknowledge bit sent by the controller, `sda_oe` is sampled twice while SCL is high. This catches output changes in the high phase and a target that is still driving SDA during the controller's acknowledge.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_WACK,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } rb_state_t;
endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] cur;
  logic [NLINES-1:0] prv;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign cur[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prv <= '1;
    else     prv <= cur;
  end

  assign scl_s     = cur[0];
  assign sda_s     = cur[1];
  assign scl_rise  = cur[0] & ~prv[0];
  assign scl_fall  = ~cur[0] & prv[0];
  assign start_det = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_det  = cur[0] & prv[0] & ~prv[1] & cur[1];
endmodule

// File: rtl/i2c_rb_file.sv
module i2c_rb_file #(
  parameter int NREG = 10,
  parameter int DW   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ptr_load,
  input  logic [DW-1:0]      load_val,
  input  logic               ptr_inc,
  input  logic               wr_en,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rd_data,
  output logic [NREG*DW-1:0] regs_flat
);
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [AW-1:0] LAST   = AW'(NREG - 1);
  localparam logic [DW-1:0] NREG_V = DW'(NREG);

  logic [DW-1:0] regs [NREG];
  logic [AW-1:0] ptr;
  logic [AW-1:0] ptr_next;

  assign ptr_next = (ptr == LAST) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (ptr_load) begin
      ptr <= (load_val < NREG_V) ? load_val[AW-1:0] : '0;
    end else if (ptr_inc) begin
      ptr <= ptr_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[ptr] <= wdata;
    end
  end

  assign rd_data = regs[ptr];

  for (genvar k = 0; k < NREG; k++) begin : g_flat
    assign regs_flat[k*DW +: DW] = regs[k];
  end

  assert_ptr_range_R3: assert property (@(posedge clk) disable iff (rst)
    ptr < AW'(NREG));

  assert_ptr_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (ptr_inc && !ptr_load && ptr == LAST) |=> (ptr == '0));

  assert_wr_lands_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (regs[$past(ptr)] == $past(wdata)));

  assert_load_clamp_R10: assert property (@(posedge clk) disable iff (rst)
    (ptr_load && load_val >= NREG_V) |=> (ptr == '0));
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2c_rb_pkg::*;
#(
  parameter int         NREG     = 10,
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int         SYNC_N   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  output logic [NREG*BYTE_W-1:0] regs_o
);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_rb_sync #(.STAGES(SYNC_N)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  rb_state_t          st;
  logic [BW-1:0]      bitcnt;
  logic               got8;
  logic [BYTE_W-1:0]  rxsh;
  logic [BYTE_W-1:0]  txsh;
  logic               rw;
  logic               first;
  logic               mack;
  logic               ld_q, inc_q, we_q;
  logic [BYTE_W-1:0]  wd_q;
  logic [BYTE_W-1:0]  rd_data;

  i2c_rb_file #(.NREG(NREG), .DW(BYTE_W)) u_file (
    .clk      (clk),
    .rst      (rst),
    .ptr_load (ld_q),
    .load_val (wd_q),
    .ptr_inc  (inc_q),
    .wr_en    (we_q),
    .wdata    (wd_q),
    .rd_data  (rd_data),
    .regs_flat(regs_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      bitcnt <= '0;
      got8   <= 1'b0;
      rxsh   <= '0;
      txsh   <= '0;
      rw     <= 1'b0;
      first  <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      ld_q   <= 1'b0;
      inc_q  <= 1'b0;
      we_q   <= 1'b0;
      wd_q   <= '0;
    end else begin
      ld_q  <= 1'b0;
      inc_q <= 1'b0;
      we_q  <= 1'b0;
      if (start_det) begin
        st     <= ST_ADDR;
        bitcnt <= '0;
        got8   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_RX: begin
            if (scl_rise && !got8) begin
              rxsh   <= {rxsh[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_BIT) got8 <= 1'b1;
            end else if (scl_fall && got8) begin
              got8   <= 1'b0;
              bitcnt <= '0;
              if (st == ST_ADDR) begin
                if (rxsh[BYTE_W-1:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  rw     <= rxsh[0];
                  first  <= 1'b1;
                  st     <= ST_AACK;
                end else begin
                  st <= ST_IGNORE;
                end
              end else begin
                sda_oe <= 1'b1;
                wd_q   <= rxsh;
                st     <= ST_WACK;
                if (first) begin
                  ld_q  <= 1'b1;
                  first <= 1'b0;
                end else begin
                  we_q  <= 1'b1;
                  inc_q <= 1'b1;
                end
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              if (rw) begin
                sda_oe <= ~rd_data[BYTE_W-1];
                txsh   <= rd_data;
                bitcnt <= '0;
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                inc_q  <= 1'b1;
                st     <= ST_MACK;
              end else begin
                sda_oe <= ~txsh[BYTE_W-2];
                txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                sda_oe <= ~rd_data[BYTE_W-1];
                txsh   <= rd_data;
                bitcnt <= '0;
                st     <= ST_TX;
              end else begin
                st <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_sda_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_s));

  assert_stop_release_R7: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  assert_mack_release_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MACK) |-> !sda_oe);

  assert_ignore_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IGNORE) |-> !sda_oe);
endmodule

// File: tb/i2c_regbank_target_tb_top.sv
module i2c_regbank_target_tb_top;
  localparam int         NREG = 10;
  localparam logic [6:0] DEV  = 7'h2C;
  localparam logic [6:0] FOREIGN = 7'h3A;
  localparam int         QTR  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  wire  sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_regbank_target #(.NREG(NREG), .DEV_ADDR(DEV)) dut_i (
    .clk   (clk),
    .rst   (rst),
    .scl_i (scl_m),
    .sda_i (sda_line),
    .sda_oe(sda_oe),
    .regs_o(regs_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] got_byte;
  event       rd_ev;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(rd_ev) begin
    if (exp_q.size() == 0) begin
      chk("scoreboard-empty", 32'(got_byte), 32'hFFFF_FFFF);
    end else begin
      chk(tag_q.pop_front(), 32'(got_byte), 32'(exp_q.pop_front()));
    end
  end

  task automatic hq();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; hq();
    sda_m = 1'b0; hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; hq();
    scl_m = 1'b1; hq();
    sda_m = 1'b0; hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq();
    scl_m = 1'b1; hq();
    sda_m = 1'b1; hq();
  endtask

  task automatic clk_bit(output logic v, output logic steady);
    logic v2;
    scl_m = 1'b1; hq();
    v = sda_line; hq();
    v2 = sda_line;
    steady = (v == v2);
    scl_m = 1'b0; hq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic v, s;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hq();
      clk_bit(v, s);
    end
    sda_m = 1'b1; hq();
    clk_bit(v, s);
    ack = ~v;
  endtask

  // Driver: pushes the expected byte, clocks it in, hands it to the monitor.
  task automatic read_exp(input logic [7:0] exp, input bit ack_it, input string tag);
    logic v, s, steady_all, rel1, rel2;
    logic [7:0] b;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    steady_all = 1'b1;
    b = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hq();
      clk_bit(v, s);
      b = {b[6:0], v};
      steady_all &= s;
    end
    sda_m = ack_it ? 1'b0 : 1'b1; hq();
    scl_m = 1'b1; hq();
    rel1 = ~sda_oe; hq();
    rel2 = ~sda_oe;
    scl_m = 1'b0; hq();
    sda_m = 1'b1;
    chk("R9 sda stable while scl high", 32'(steady_all), 32'd1);
    chk("R9 released in controller ack", 32'(rel1 & rel2), 32'd1);
    got_byte = b;
    ->rd_ev;
    @(negedge clk);
  endtask

  function automatic logic [7:0] reg_at(input int k);
    return regs_o[k*8 +: 8];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 regs cleared", 32'(regs_o == '0), 32'd1);
    chk("R1 sda released", 32'(sda_oe), 32'd0);

    // R2 write burst from pointer 0
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk("R2 address ack", 32'(ack), 32'd1);
    send_byte(8'h00, ack);       chk("R2 pointer byte ack", 32'(ack), 32'd1);
    send_byte(8'h10, ack);
    send_byte(8'h11, ack);
    send_byte(8'h12, ack);
    send_byte(8'h13, ack);       chk("R2 data ack", 32'(ack), 32'd1);
    bus_stop();
    chk("R2 reg0", 32'(reg_at(0)), 32'h10);
    chk("R2 reg3", 32'(reg_at(3)), 32'h13);

    // R3 write wrap 8 -> 9 -> 0
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h08, ack);
    send_byte(8'hA1, ack);
    send_byte(8'hB2, ack);
    send_byte(8'hC3, ack);
    bus_stop();
    chk("R3 reg8", 32'(reg_at(8)), 32'hA1);
    chk("R3 reg9", 32'(reg_at(9)), 32'hB2);
    chk("R3 wrap into reg0", 32'(reg_at(0)), 32'hC3);
    chk("R3 reg1 untouched", 32'(reg_at(1)), 32'h11);

    // R4 current-address read after a write: pointer is 1
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk("R4 read address ack", 32'(ack), 32'd1);
    read_exp(8'h11, 1'b1, "R4 current read after write");
    read_exp(8'h12, 1'b0, "R6 burst next byte");
    bus_stop();
    chk("R7 released after nack+stop", 32'(sda_oe), 32'd0);

    // R4 current-address read after a read: pointer is 3
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    read_exp(8'h13, 1'b0, "R4 current read after read");
    bus_stop();

    // R5 random read with wrap, R6 MSB-first via 0xA1/0xB2 patterns
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h09, ack);
    bus_rstart();
    send_byte({DEV, 1'b1}, ack); chk("R5 ack after repeated start", 32'(ack), 32'd1);
    read_exp(8'hB2, 1'b1, "R5 random read start");
    read_exp(8'hC3, 1'b1, "R3 read wrap to reg0");
    read_exp(8'h11, 1'b0, "R6 burst after wrap");
    bus_stop();
    chk("R7 released at end", 32'(sda_oe), 32'd0);

    // R8 foreign address: no ack, no effect
    bus_start();
    send_byte({FOREIGN, 1'b0}, ack); chk("R8 no ack on foreign address", 32'(ack), 32'd0);
    send_byte(8'h00, ack);           chk("R8 no ack on ignored byte", 32'(ack), 32'd0);
    send_byte(8'h55, ack);
    bus_stop();
    chk("R8 reg0 unchanged", 32'(reg_at(0)), 32'hC3);
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    read_exp(8'h12, 1'b0, "R8 pointer unchanged");
    bus_stop();

    // R10 oversized pointer byte clamps to 0
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h20, ack);
    send_byte(8'h77, ack);
    bus_stop();
    chk("R10 clamp writes reg0", 32'(reg_at(0)), 32'h77);
    chk("R10 reg2 untouched", 32'(reg_at(2)), 32'h12);

    repeat (10) @(negedge clk);
    chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule